// File: doc/BRIEF.md
# Configuration Register Bank with Mode-Gated Readback

This block holds the configuration state of a device behind a simple synchronous host bus. It has one 8-bit top control word and a parameterised set of ordinary read/write registers. The top control word is written at address 0x00. A bus-view bit inside it chooses what reads can see. With the bit clear, the ordinary registers read back normally and the top word stays hidden. With the bit set, the top word is read through address 0x01 and every other address is hidden.

The top word also carries a self-timed soft reset bit. Writing it starts a reset pulse of fixed length on a device-wide reset output. For the whole pulse the bank returns to its defaults and ignores writes. The other fields of the top word drive level outputs: sample-rate range, open-drain mode, sleep and power-down. An asynchronous active-low hardware reset puts the bank into the same state and overrides any pulse that is running.

Top module: `cfg_bank`

## Requirements
- R1: While the hardware reset is low, and on its release, every level output, `dev_rst_o`, `gp_o`, `rd_data_o` and `rd_err_o` is zero.
- R2: An accepted write to address 0x00 sets the outputs from the written byte as follows: bit 4 to `rate_lo_o`, bit 2 to `od_mode_o`, bit 1 to `sleep_o` and bit 0 to `pdn_o`. The outputs take the new values after the write edge.
- R3: When the bus-view bit (bit 5 of the top word) is 1, a read of 0x01 returns {2'b00, 1, rate, 0, od, sleep, pdn}, with the reserved bits 7:6 always 0. A read of any other address, 0x00 included, is an error read.
- R4: When the bus-view bit is 0, a read of ordinary register k, at address 0x02+k, returns its last accepted write. Reads of 0x00 and 0x01 are error reads.
- R5: An error read returns 0x00 on `rd_data_o` and raises `rd_err_o`. `rd_err_o` is high only in the cycle after a read strobe that produced an error read.
- R6: Read data appears on `rd_data_o` in the cycle after the read strobe, and is 0x00 in any cycle not preceded by a read strobe.
- R7: An accepted write to 0x00 with bit 3 set raises `dev_rst_o` after that edge. The pulse stays high for exactly SRST_CYCLES = CLK_MHZ*SRST_US cycles and then clears itself.
- R8: While `dev_rst_o` is high, every register holds its default value, the bus-view bit included. All level outputs and `gp_o` read zero, and the bank is in normal read mode once the pulse ends.
- R9: Writes that arrive while `dev_rst_o` is high have no effect.
- R10: The hardware reset acts at once, without waiting for a clock edge, and ends a soft reset pulse that is in progress.
- R11: Writes to 0x01 or to any address above the ordinary range are ignored. Reads of such addresses are error reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr_i | input | 8 | Bus address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| rd_err_o | output | 1 | One-cycle flag for a hidden or unmapped read |
| rate_lo_o | output | 1 | Lower sample-rate range selected |
| od_mode_o | output | 1 | Open-drain output mode |
| sleep_o | output | 1 | Sleep request |
| pdn_o | output | 1 | Power-down request |
| dev_rst_o | output | 1 | Device-wide soft reset pulse |
| gp_o | output | 8*NUM_GP | Contents of the ordinary registers, register 0 in the low byte |

## Verification
The assertions assume that the hardware reset is held low across at least one clock edge. A pulse shorter than one cycle would let the pulse-length counter miss a cut-short pulse. They also assume the strobes are low during reset, so that the first post-reset comparison with the previous cycle is clean. The bench drives all inputs on the falling edge and holds the strobes low whenever reset is asserted. It asserts the hardware reset only between rising edges and keeps it low for several edges. Random stimulus uses a fixed seed and sets bit 3 on only a small share of top-word writes, so that many soft reset pulses fit in the run without taking over the traffic.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] ADDR_TOP   = 8'h00;
  localparam logic [AW-1:0] ADDR_ALIAS = 8'h01;
  localparam logic [AW-1:0] ADDR_GP0   = 8'h02;

  localparam int B_VIEW = 5;
  localparam int B_RATE = 4;
  localparam int B_SRST = 3;
  localparam int B_OD   = 2;
  localparam int B_SLP  = 1;
  localparam int B_PDN  = 0;

  typedef struct packed {
    logic view;
    logic rate;
    logic od;
    logic slp;
    logic pdn;
  } top_fields_t;

  function automatic int pulse_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic logic [DW-1:0] top_image(input top_fields_t f, input logic srst);
    logic [DW-1:0] v;
    v = '0;
    v[B_VIEW] = f.view;
    v[B_RATE] = f.rate;
    v[B_SRST] = srst;
    v[B_OD]   = f.od;
    v[B_SLP]  = f.slp;
    v[B_PDN]  = f.pdn;
    return v;
  endfunction

  function automatic logic in_gp_range(input logic [AW-1:0] a, input int n);
    return (int'(a) >= int'(ADDR_GP0)) && (int'(a) < int'(ADDR_GP0) + n);
  endfunction
endpackage

// File: rtl/cfg_top_ctrl.sv
module cfg_top_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int SRST_CYCLES = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_top,
  input  logic [DW-1:0] wdata,
  output top_fields_t   fields,
  output logic          srst_active,
  output logic          srst_req
);
  localparam int CW = $clog2(SRST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SRST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign srst_req = wr_top && wdata[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_active <= 1'b0;
      cnt_q       <= '0;
    end else if (srst_req) begin
      srst_active <= 1'b1;
      cnt_q       <= '0;
    end else if (srst_active) begin
      if (cnt_q == LAST) begin
        srst_active <= 1'b0;
        cnt_q       <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else if (srst_req || srst_active) begin
      fields <= '0;
    end else if (wr_top) begin
      fields.view <= wdata[B_VIEW];
      fields.rate <= wdata[B_RATE];
      fields.od   <= wdata[B_OD];
      fields.slp  <= wdata[B_SLP];
      fields.pdn  <= wdata[B_PDN];
    end
  end
endmodule

// File: rtl/cfg_gp_regs.sv
module cfg_gp_regs
  import cfg_bank_pkg::*;
#(
  parameter int NUM_GP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_ok,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NUM_GP*DW-1:0] regs_flat
);
  for (genvar k = 0; k < NUM_GP; k++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(ADDR_GP0) + k);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (clr)                        q <= '0;
      else if (wr_ok && addr == MY_ADDR)   q <= wdata;
    end
    assign regs_flat[k*DW +: DW] = q;
  end
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfg_bank_pkg::*;
#(
  parameter int NUM_GP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  top_fields_t          fields,
  input  logic                 srst_active,
  input  logic [NUM_GP*DW-1:0] regs_flat,
  output logic                 hit,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_err
);
  localparam int IW = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  logic [DW-1:0] sel_data;
  logic [AW-1:0] offs;

  assign offs = addr - ADDR_GP0;

  always_comb begin
    hit      = 1'b0;
    sel_data = '0;
    if (fields.view) begin
      if (addr == ADDR_ALIAS) begin
        hit      = 1'b1;
        sel_data = top_image(fields, srst_active);
      end
    end else if (in_gp_range(addr, NUM_GP)) begin
      hit      = 1'b1;
      sel_data = regs_flat[int'(offs[IW-1:0])*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= (rd_en && hit) ? sel_data : '0;
      rd_err  <= rd_en && !hit;
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int SRST_US = 2,
  parameter int NUM_GP  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  output logic [7:0]           rd_data_o,
  output logic                 rd_err_o,
  output logic                 rate_lo_o,
  output logic                 od_mode_o,
  output logic                 sleep_o,
  output logic                 pdn_o,
  output logic                 dev_rst_o,
  output logic [8*NUM_GP-1:0]  gp_o
);
  localparam int SRST_CYCLES = pulse_cycles(CLK_MHZ, SRST_US);

  top_fields_t fields_w;
  logic        srst_active_w;
  logic        srst_req_w;
  logic        wr_accept_w;
  logic        bank_clr_w;
  logic        rd_hit_w;
  logic [NUM_GP*DW-1:0] gp_w;

  assign wr_accept_w = wr_en_i && !srst_active_w;
  assign bank_clr_w  = srst_req_w || srst_active_w;

  cfg_top_ctrl #(.SRST_CYCLES(SRST_CYCLES)) u_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_top     (wr_accept_w && addr_i == ADDR_TOP),
    .wdata      (wdata_i),
    .fields     (fields_w),
    .srst_active(srst_active_w),
    .srst_req   (srst_req_w)
  );

  cfg_gp_regs #(.NUM_GP(NUM_GP)) u_gp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bank_clr_w),
    .wr_ok    (wr_accept_w),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .regs_flat(gp_w)
  );

  cfg_read_port #(.NUM_GP(NUM_GP)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en_i),
    .addr       (addr_i),
    .fields     (fields_w),
    .srst_active(srst_active_w),
    .regs_flat  (gp_w),
    .hit        (rd_hit_w),
    .rd_data    (rd_data_o),
    .rd_err     (rd_err_o)
  );

  assign rate_lo_o = fields_w.rate;
  assign od_mode_o = fields_w.od;
  assign sleep_o   = fields_w.slp;
  assign pdn_o     = fields_w.pdn;
  assign dev_rst_o = srst_active_w;
  assign gp_o      = gp_w;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
  parameter int SRST_CYCLES = 100,
  parameter int NUM_GP      = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          addr_i,
  input logic [7:0]          wdata_i,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [7:0]          rd_data_o,
  input logic                rd_err_o,
  input logic                rate_lo_o,
  input logic                od_mode_o,
  input logic                sleep_o,
  input logic                pdn_o,
  input logic                dev_rst_o,
  input logic [8*NUM_GP-1:0] gp_o,
  input logic                wr_accept_w
);
  localparam int LW = $clog2(SRST_CYCLES + 2);
  logic [LW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (dev_rst_o) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> rd_data_o == 8'h00); // R5
  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> $past(rd_en_i)); // R5
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en_i) |-> rd_data_o == 8'h00); // R6
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_o) |-> $past(wr_en_i && addr_i == 8'h00 && wdata_i[3])); // R7
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hi_len) <= SRST_CYCLES); // R7
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rst_o) |-> int'(hi_len) == SRST_CYCLES); // R7
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> !(rate_lo_o || od_mode_o || sleep_o || pdn_o) && gp_o == '0); // R8
  AST_PULSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_o && wr_en_i) |=> gp_o == '0); // R9
endmodule

bind cfg_bank cfg_bank_chk #(.SRST_CYCLES(SRST_CYCLES), .NUM_GP(NUM_GP)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .rd_err_o(rd_err_o), .rate_lo_o(rate_lo_o), .od_mode_o(od_mode_o),
  .sleep_o(sleep_o), .pdn_o(pdn_o), .dev_rst_o(dev_rst_o), .gp_o(gp_o),
  .wr_accept_w(wr_accept_w)
);

// File: tb/cfg_bank_bench.sv
module cfg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 50;
  localparam int US  = 2;
  localparam int NGP = 4;
  localparam int PULSE = MHZ * US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_err, rate_lo, od_mode, sleep_s, pdn, dev_rst;
  logic [8*NGP-1:0] gp;

  int checks = 0;
  int errors = 0;

  // bench model
  logic m_view, m_rate, m_od, m_slp, m_pdn;
  logic [7:0] m_gp [NGP];
  int m_left;
  logic [7:0] exp_rd;
  logic exp_err;

  cfg_bank #(.CLK_MHZ(MHZ), .SRST_US(US), .NUM_GP(NGP)) u_cfg_bank (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr), .rd_en_i(rd), .rd_data_o(rd_data), .rd_err_o(rd_err),
    .rate_lo_o(rate_lo), .od_mode_o(od_mode), .sleep_o(sleep_s), .pdn_o(pdn),
    .dev_rst_o(dev_rst), .gp_o(gp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_view = 0; m_rate = 0; m_od = 0; m_slp = 0; m_pdn = 0;
    for (int k = 0; k < NGP; k++) m_gp[k] = '0;
  endfunction

  function automatic logic [7:0] view_image();
    return {2'b00, 1'b1, m_rate, 1'b0, m_od, m_slp, m_pdn};
  endfunction

  function automatic logic [8*NGP-1:0] gp_image();
    logic [8*NGP-1:0] v;
    for (int k = 0; k < NGP; k++) v[k*8 +: 8] = m_gp[k];
    return v;
  endfunction

  // one bus cycle: drive on falling edge, update model at rising edge, check after it
  task automatic cycle(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    // expected read from pre-edge state
    exp_rd = 8'h00; exp_err = 1'b0;
    if (r) begin
      if (m_view) begin
        if (a == 8'h01) exp_rd = view_image(); else exp_err = 1'b1;
      end else if (a >= 8'h02 && a < 8'h02 + NGP) exp_rd = m_gp[a - 8'h02];
      else exp_err = 1'b1;
    end
    @(posedge clk);
    if (m_left > 0) begin
      m_left--;
    end else if (w) begin
      if (a == 8'h00) begin
        if (d[3]) begin m_left = PULSE; model_clear(); end
        else begin m_view = d[5]; m_rate = d[4]; m_od = d[2]; m_slp = d[1]; m_pdn = d[0]; end
      end else if (a >= 8'h02 && a < 8'h02 + NGP) m_gp[a - 8'h02] = d;
    end
    #1;
    if (r) begin
      if (exp_err) chk("R5 err read data/flag", {rd_err, rd_data}, {1'b1, 8'h00});
      else if (m_view || a == 8'h01) chk("R3 view read", {rd_err, rd_data}, {1'b0, exp_rd});
      else chk("R4 normal read", {rd_err, rd_data}, {1'b0, exp_rd});
    end else begin
      chk("R6 idle read port", {rd_err, rd_data}, 9'h000);
    end
    chk("R2 level outputs", {rate_lo, od_mode, sleep_s, pdn}, {m_rate, m_od, m_slp, m_pdn});
    chk("R7 pulse level", dev_rst, m_left > 0);
    chk("R8/R9 gp contents", gp, gp_image());
  endtask

  task automatic hw_reset();
    @(negedge clk);
    wr = 0; rd = 0;
    #2 rst_n = 1'b0;
    #1;
    model_clear(); m_left = 0;
    chk("R10 async reset outputs", {dev_rst, rate_lo, od_mode, sleep_s, pdn, gp},
        '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    model_clear(); m_left = 0;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {rd_data, rd_err, rate_lo, od_mode, sleep_s, pdn, dev_rst, gp}, '0);
    @(negedge clk) rst_n = 1'b1;

    // R2 / R4: fields and ordinary registers
    cycle(1, 0, 8'h00, 8'h17);
    for (int k = 0; k < NGP; k++) cycle(1, 0, 8'h02 + 8'(k), 8'hA0 + 8'(k));
    for (int k = 0; k < NGP; k++) cycle(0, 1, 8'h02 + 8'(k), 8'h00);
    cycle(0, 1, 8'h00, 8'h00); // R4 top hidden
    cycle(0, 1, 8'h01, 8'h00); // R4 alias hidden
    // R11 unmapped
    cycle(1, 0, 8'h01, 8'hFF);
    cycle(1, 0, 8'h40, 8'hFF);
    cycle(0, 1, 8'h40, 8'h00);
    // R3 view mode, reserved bits written as ones read zero
    cycle(1, 0, 8'h00, 8'hF7);
    cycle(0, 1, 8'h01, 8'h00);
    cycle(0, 1, 8'h02, 8'h00); // R3 hidden
    cycle(0, 1, 8'h00, 8'h00); // R3 hidden
    // R7 / R8 / R9: pulse, with writes during it
    cycle(1, 1, 8'h00, 8'h3F);
    for (int i = 0; i < PULSE + 3; i++) cycle(1, (i % 7) == 0, 8'h02 + 8'(i % NGP), 8'h55);
    cycle(0, 1, 8'h02, 8'h00); // R8 normal mode after pulse
    // R10 cut a pulse short
    cycle(1, 0, 8'h02, 8'h99);
    cycle(1, 0, 8'h00, 8'h08);
    repeat (5) cycle(0, 0, 8'h00, 8'h00);
    hw_reset();
    cycle(1, 0, 8'h03, 8'h42); // R10 writes accepted right after
    cycle(0, 1, 8'h03, 8'h00);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, d;
      logic w, r;
      a = 8'($urandom_range(0, NGP + 3));
      d = 8'($urandom);
      if (a == 8'h00 && ($urandom_range(0, 29) != 0)) d[3] = 1'b0;
      w = ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 1) == 0);
      if (i == 2500) hw_reset();
      cycle(w, r, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule